// File: doc/BRIEF.md
# Codec interrupt flag and mask unit

This block gathers the event indications of an audio codec into one flag register and raises a single interrupt line toward the host. There are six sticky events: gain-down done, gain-up done, ramp-down done, ramp-up done, short-circuit detected and jack changed. A seventh flag bit is not sticky. It shows the present, synchronised level of the jack-detect input. Software clears the sticky flags by writing ones to them.

A control register holds two things. The first is a per-event mask. The second is a 2-bit selector that sets the electrical form of the interrupt line: active-high level, active-low level, a one-cycle high pulse or a one-cycle low pulse. The event generators sit outside this block. Each one delivers a single-cycle pulse. The jack input may be asynchronous, and it is synchronised inside the block.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the flag register (`flag_o`) reads 0x00, the control register (`ctrl_o`) reads 0x3F (all six events masked, form 00), and `irq_o` is low.
- R2: A cycle with `flag_we_i` high clears every flag bit among 5:0 whose `flag_wdata_i` bit is 1. Flag bits whose write bit is 0 keep their value.
- R3: An event that sets a flag in the same cycle as a clear write to that flag wins: the flag is set after that edge.
- R4: A pulse on `evt_i[k]` for k = 0..4 sets flag bit k on the next clock edge. The flag order is: bit 0 gain-down done, bit 1 gain-up done, bit 2 ramp-down done, bit 3 ramp-up done, bit 4 short-circuit.
- R5: `jack_i` passes through a 2-stage synchroniser. Flag bit 6 equals the synchronised level two edges after a change. Flag bit 5 sets one edge later, on both rising and falling changes. Clear writes never alter bit 6.
- R6: Control bits 5:0 mask flag bits 5:0 position by position, with 1 meaning masked. An interrupt is pending while any unmasked flag among bits 5:0 is set.
- R7: Form 00 (control bits 7:6) drives `irq_o` high while an interrupt is pending. Form 01 drives it low while an interrupt is pending.
- R8: Form 10 drives `irq_o` high for exactly one cycle when the pending state goes from none to some, and low otherwise. Form 11 is the inverse: a one-cycle low pulse, high when idle.
- R9: A cycle with `ctrl_we_i` high loads `ctrl_wdata_i` into the control register, which reads back unchanged on `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Single-cycle event pulses for flag bits 4:0 |
| jack_i | input | 1 | Asynchronous jack-detect level |
| flag_we_i | input | 1 | Write strobe for flag clearing |
| flag_wdata_i | input | 6 | Write-one-to-clear data for flag bits 5:0 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| flag_o | output | 7 | Flag register: bits 5:0 sticky events, bit 6 jack level |
| ctrl_o | output | 8 | Control register: bits 7:6 form, bits 5:0 masks |
| irq_o | output | 1 | Interrupt output |

## Verification
Two cases are hard to reach from the ports. The first is an event that coincides with a clear write to the same flag. The stimulus drives `evt_i` and `flag_we_i` in the same cycle, and also clears a different flag in that write, so that the set-wins rule is checked alongside a clear that takes effect. The second is the pulse forms. They need a pending state that is already high when a second event arrives. The bench raises one event, lets the pulse expire, and then adds another unmasked event to show that no second pulse appears. The mask behaviour is swept over all 64 mask values, for each pulse-driven event, in both level forms.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int unsigned FLAG_W  = 6;
  localparam int unsigned PULSE_W = 5;
  localparam int unsigned CTRL_W  = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h3F;

  typedef enum logic [1:0] {
    FORM_LVL_HI = 2'b00,
    FORM_LVL_LO = 2'b01,
    FORM_PLS_HI = 2'b10,
    FORM_PLS_LO = 2'b11
  } irq_form_e;
endpackage

// File: rtl/jack_sync.sv
module jack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic jack_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], jack_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (set_i[k]) flag_q[k] <= 1'b1;   // set beats clear
      else if (clr_m[k]) flag_q[k] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((flag_q & $past(clr_i & ~set_i)) == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> $stable(flag_q)); // R2
endmodule

// File: rtl/irq_out.sv
module irq_out
  import codec_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pending_i,
  input  irq_form_e form_i,
  output logic      irq_o
);
  logic pend_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pending_i;
  end

  assign rise = pending_i & ~pend_q;

  always_comb begin
    unique case (form_i)
      FORM_LVL_HI: irq_o = pending_i;
      FORM_LVL_LO: irq_o = ~pending_i;
      FORM_PLS_HI: irq_o = rise;
      FORM_PLS_LO: irq_o = ~rise;
      default:     irq_o = pending_i;
    endcase
  end

  AST_PULSE_HI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_i == FORM_PLS_HI && irq_o) |=> (form_i != FORM_PLS_HI || !irq_o)); // R8
  AST_PULSE_LO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_i == FORM_PLS_LO && !irq_o) |=> (form_i != FORM_PLS_LO || irq_o)); // R8
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
  import codec_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PULSE_W-1:0]   evt_i,
  input  logic                 jack_i,
  input  logic                 flag_we_i,
  input  logic [FLAG_W-1:0]    flag_wdata_i,
  input  logic                 ctrl_we_i,
  input  logic [CTRL_W-1:0]    ctrl_wdata_i,
  output logic [FLAG_W:0]      flag_o,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic                 irq_o
);
  logic              jack_lvl, jack_edge, pending;
  logic [FLAG_W-1:0] flags, set_vec;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  jack_sync #(.STAGES(SYNC_STAGES)) u_jack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .jack_i (jack_i),
    .lvl_o  (jack_lvl),
    .edge_o (jack_edge)
  );

  assign set_vec = {jack_edge, evt_i};

  irq_flags #(.W(FLAG_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_we_i (flag_we_i),
    .clr_i    (flag_wdata_i),
    .flag_o   (flags)
  );

  assign pending = |(flags & ~ctrl_q[FLAG_W-1:0]);

  irq_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .form_i    (irq_form_e'(ctrl_q[CTRL_W-1:CTRL_W-2])),
    .irq_o     (irq_o)
  );

  assign flag_o = {jack_lvl, flags};
  assign ctrl_o = ctrl_q;

  AST_JACK_EDGE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[FLAG_W] != $past(flag_o[FLAG_W])) |=> flag_o[FLAG_W-1]); // R5
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == $past(ctrl_wdata_i))); // R9
endmodule

// File: tb/tb_codec_irq_unit.sv
module tb_codec_irq_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] evt_i = '0;
  logic       jack_i = 1'b0;
  logic       flag_we_i = 1'b0;
  logic [5:0] flag_wdata_i = '0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [6:0] flag_o;
  logic [7:0] ctrl_o;
  logic       irq_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  codec_irq_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .jack_i(jack_i),
    .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .flag_o(flag_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_flag(input logic [5:0] v);
    flag_we_i = 1'b1; flag_wdata_i = v;
    @(negedge clk_i);
    flag_we_i = 1'b0;
  endtask

  task automatic pulse_evt(input int k);
    evt_i = 5'(1 << k);
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(flag_o, 'h00, "R1 flags");
    check(ctrl_o, 'h3F, "R1 ctrl");
    check(irq_o, 0, "R1 irq");

    // R9 control readback
    wr_ctrl(8'hA5);
    check(ctrl_o, 'hA5, "R9 readback");
    wr_ctrl(8'h3F);
    check(ctrl_o, 'h3F, "R9 readback");

    // R4 event mapping, R2 write-0 keeps, write-1 clears
    for (int k = 0; k < 5; k++) begin
      pulse_evt(k);
      check(flag_o, 1 << k, "R4 mapping");
      wr_flag(6'h00);
      check(flag_o, 1 << k, "R2 zero write keeps");
      wr_flag(6'(~(1 << k)));
      check(flag_o, 1 << k, "R2 other bits keep");
      wr_flag(6'(1 << k));
      check(flag_o, 0, "R2 clear");
    end

    // R6/R7 full mask sweep in both level forms
    for (int f = 0; f < 2; f++) begin
      for (int m = 0; m < 64; m++) begin
        for (int k = 0; k < 5; k++) begin
          wr_ctrl(8'((f << 6) | m));
          pulse_evt(k);
          begin
            int pend;
            pend = ((m >> k) & 1) ? 0 : 1;
            check(irq_o, f ? (1 - pend) : pend, "R6 R7 mask/level");
          end
          wr_flag(6'h3F);
        end
      end
    end

    // R5 jack sync, both edges, level bit unaffected by clear
    wr_ctrl(8'h3F);
    jack_i = 1'b1;
    @(negedge clk_i);
    check(flag_o[6], 0, "R5 stage1");
    @(negedge clk_i);
    check(flag_o[6], 1, "R5 level");
    check(flag_o[5], 0, "R5 event not yet");
    @(negedge clk_i);
    check(flag_o[5], 1, "R5 rising event");
    wr_flag(6'h3F);
    check(flag_o, 'h40, "R5 clear leaves level");
    wr_ctrl(8'h1F);
    jack_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(flag_o, 'h20, "R5 falling event");
    check(irq_o, 1, "R6 jack unmasked");
    wr_flag(6'h20);
    check(irq_o, 0, "R6 jack cleared");

    // R3 set beats clear, other flag still clears
    wr_ctrl(8'h3F);
    pulse_evt(0);
    evt_i = 5'b00100; flag_we_i = 1'b1; flag_wdata_i = 6'b000101;
    @(negedge clk_i);
    evt_i = '0; flag_we_i = 1'b0;
    check(flag_o, 'h04, "R3 set wins");
    wr_flag(6'h3F);

    // R8 high pulse
    wr_ctrl(8'h80);
    check(irq_o, 0, "R8 idle low");
    pulse_evt(1);
    check(irq_o, 1, "R8 pulse high");
    @(negedge clk_i);
    check(irq_o, 0, "R8 pulse one cycle");
    pulse_evt(3);
    check(irq_o, 0, "R8 no repulse while pending");
    wr_flag(6'h3F);
    check(irq_o, 0, "R8 cleared");
    pulse_evt(4);
    check(irq_o, 1, "R8 new pulse after clear");
    wr_flag(6'h3F);

    // R8 low pulse
    wr_ctrl(8'hC0);
    check(irq_o, 1, "R8 idle high");
    pulse_evt(2);
    check(irq_o, 0, "R8 pulse low");
    @(negedge clk_i);
    check(irq_o, 1, "R8 low pulse one cycle");
    wr_flag(6'h3F);

    finish_run();
  end
endmodule